// File: doc/BRIEF.md
# BCD Calendar Counter with Century

This block keeps wall-clock time and calendar date as a chain of packed BCD counters advanced by a one-second tick enable. Seconds, minutes and hours (24-hour form) roll into a day carry. The day carry steps both the date and a separate day-of-week counter. The date rolls into the month, the month into the year and the year into the century. Month lengths and the February leap day are worked out directly from the BCD month and year. The leap rule is the plain divisible-by-four test on the two-digit year.

A register interface presets every field at once through a parallel load, and a halt input freezes counting without disturbing the stored values. All carries settle inside the tick's clock cycle, so the outputs never show a partially rolled-over time. Loaded values are not range-checked. Counting runs on from them until a field reaches its own wrap value.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read century 00, year 00, month 01, date 01, weekday 01, hours 00, minutes 00, seconds 00.
- R2: Each clock cycle with `sec_tick`=1 and `halt`=0 advances seconds by one in BCD. Seconds and minutes run 00 to 59 and then return to 00, and a return passes a carry to the next field. Each output is two BCD digits: bits [7:4] are tens, bits [3:0] are units.
- R3: Hours run 00 to 23 in 24-hour form. Hour 23 returning to 00 produces the day carry, and a units-digit overflow from 09 gives 10.
- R4: The last date is 30 for months 04, 06, 09 and 11. It is 31 for months 01, 03, 05, 07, 08, 10 and 12. It is 28 for month 02 in a common year and 29 in a leap year. After the last date, the date returns to 01 and the month advances.
- R5: A year is a leap year when its tens digit is even and its units digit is 0, 4 or 8, or when its tens digit is odd and its units digit is 2 or 6.
- R6: Month 12 returns to 01 and advances the year. Year 99 returns to 00 and advances the century. Century 39 returns to 00.
- R7: At every day carry the weekday advances from 01 through 07 and then back to 01, whatever the date does.
- R8: While `halt`=1, ticks have no effect and every field keeps its value.
- R9: `load`=1 writes all eight load inputs into the fields in the same cycle, and takes priority over a tick in that cycle. Counting then continues from the loaded values.
- R10: A tick at 23:59:59 on the last day of a month, a year or a century updates every affected field in the same cycle.
- R11: A loaded out-of-range value is kept as it is. It is incremented in BCD at each step until the field reaches its wrap value. For example, seconds loaded as 75 step to 76, and hours loaded as 25 step to 26 with no day carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle enable once per second |
| halt | input | 1 | 1 freezes counting |
| load | input | 1 | 1 presets all fields from the load inputs |
| ld_seconds | input | 8 | BCD seconds to load |
| ld_minutes | input | 8 | BCD minutes to load |
| ld_hours | input | 8 | BCD hours to load |
| ld_weekday | input | 8 | BCD weekday to load |
| ld_mday | input | 8 | BCD date to load |
| ld_month | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| ld_century | input | 8 | BCD century to load |
| seconds | output | 8 | BCD seconds |
| minutes | output | 8 | BCD minutes |
| hours | output | 8 | BCD hours |
| weekday | output | 8 | BCD weekday |
| mday | output | 8 | BCD date |
| month | output | 8 | BCD month |
| year | output | 8 | BCD year |
| century | output | 8 | BCD century |

## Verification
The bench builds the block with its default parameters: century wrap at 39, weekday wrap at 07 and hour wrap at 23. With these values, loading 39-99-12-31 23:59:59 exercises the full century wrap in a single tick. Loading just before midnight on chosen dates exercises every month length and both branches of the leap rule, including odd-tens years and the year 00, without running through long stretches of time. A one-hour run of 3600 ticks shows the whole seconds, minutes and hours chain cascading into the date.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BCD_W = 8;
  typedef logic [BCD_W-1:0] bcd_t;

  function automatic bcd_t bcd_inc(input bcd_t v);
    bcd_t r;
    if (v[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
    end else begin
      r[3:0] = v[3:0] + 4'd1;
      r[7:4] = v[7:4];
    end
    return r;
  endfunction
endpackage

// File: rtl/cal_reset_sync.sv
module cal_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/cal_month_days.sv
module cal_month_days
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  bcd_t month_i,
  input  bcd_t year_i,
  output bcd_t last_day_o,
  output logic leap_o
);
  logic tens_odd;
  logic [3:0] units;

  always_comb begin
    tens_odd = year_i[4];
    units    = year_i[3:0];
    if (tens_odd) leap_o = (units == 4'd2) || (units == 4'd6);
    else          leap_o = (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
  end

  always_comb begin
    unique case (month_i)
      8'h02:                      last_day_o = leap_o ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end

  // R4: the month length is always one of the four legal values
  assert_days_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_day_o == 8'h28) || (last_day_o == 8'h29) ||
    (last_day_o == 8'h30) || (last_day_o == 8'h31));

  // R5: a 29-day month only occurs in February
  assert_leap_feb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_day_o == 8'h29) |-> (month_i == 8'h02));
endmodule

// File: rtl/cal_field_cnt.sv
module cal_field_cnt
  import cal_pkg::*;
#(
  parameter bcd_t FIRST = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  bcd_t last_i,
  output bcd_t val_o,
  output logic wrap_o
);
  bcd_t val_q, val_d;
  logic en;

  assign wrap_o = inc_i && !ld_i && (val_q == last_i);
  assign en     = ld_i || inc_i;

  always_comb begin
    if (ld_i)        val_d = ld_val_i;
    else if (wrap_o) val_d = FIRST;
    else             val_d = bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= FIRST;
    else if (en) val_q <= val_d;
  end

  assign val_o = val_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !inc_i) |=> $stable(val_q));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (val_q == $past(ld_val_i)));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && (val_q == last_i)) |=> (val_q == FIRST));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter logic [7:0] CENT_LAST = 8'h39,
  parameter logic [7:0] WEEK_LAST = 8'h07,
  parameter logic [7:0] HOUR_LAST = 8'h23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       halt,
  input  logic       load,
  input  logic [7:0] ld_seconds,
  input  logic [7:0] ld_minutes,
  input  logic [7:0] ld_hours,
  input  logic [7:0] ld_weekday,
  input  logic [7:0] ld_mday,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_century,
  output logic [7:0] seconds,
  output logic [7:0] minutes,
  output logic [7:0] hours,
  output logic [7:0] weekday,
  output logic [7:0] mday,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [7:0] century
);
  // Field slots: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 century, 7 weekday
  localparam int NF    = 8;
  localparam int I_SEC = 0, I_MIN = 1, I_HR = 2, I_DATE = 3;
  localparam int I_MON = 4, I_YR  = 5, I_CEN = 6, I_WDAY = 7;
  localparam bcd_t FIRST_V [NF] = '{8'h00, 8'h00, 8'h00, 8'h01,
                                    8'h01, 8'h00, 8'h00, 8'h01};

  logic rst_n_i;
  logic step;
  bcd_t last_day;
  logic leap;
  bcd_t f_ld   [NF];
  bcd_t f_last [NF];
  bcd_t f_val  [NF];
  logic [NF-1:0] f_inc;
  logic [NF-1:0] f_wrap;

  cal_reset_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign step = sec_tick && !halt;

  cal_month_days i_mdays (
    .clk(clk), .rst_n(rst_n_i),
    .month_i(f_val[I_MON]), .year_i(f_val[I_YR]),
    .last_day_o(last_day), .leap_o(leap)
  );

  always_comb begin
    f_ld[I_SEC]  = ld_seconds;
    f_ld[I_MIN]  = ld_minutes;
    f_ld[I_HR]   = ld_hours;
    f_ld[I_DATE] = ld_mday;
    f_ld[I_MON]  = ld_month;
    f_ld[I_YR]   = ld_year;
    f_ld[I_CEN]  = ld_century;
    f_ld[I_WDAY] = ld_weekday;

    f_last[I_SEC]  = 8'h59;
    f_last[I_MIN]  = 8'h59;
    f_last[I_HR]   = HOUR_LAST;
    f_last[I_DATE] = last_day;
    f_last[I_MON]  = 8'h12;
    f_last[I_YR]   = 8'h99;
    f_last[I_CEN]  = CENT_LAST;
    f_last[I_WDAY] = WEEK_LAST;

    f_inc[I_SEC] = step;
    for (int k = 1; k < I_WDAY; k++) f_inc[k] = f_wrap[k-1];
    f_inc[I_WDAY] = f_wrap[I_HR];
  end

  for (genvar g = 0; g < NF; g++) begin : g_field
    cal_field_cnt #(.FIRST(FIRST_V[g])) i_cnt (
      .clk(clk), .rst_n(rst_n_i),
      .inc_i(f_inc[g]), .ld_i(load),
      .ld_val_i(f_ld[g]), .last_i(f_last[g]),
      .val_o(f_val[g]), .wrap_o(f_wrap[g])
    );
  end

  assign seconds = f_val[I_SEC];
  assign minutes = f_val[I_MIN];
  assign hours   = f_val[I_HR];
  assign mday    = f_val[I_DATE];
  assign month   = f_val[I_MON];
  assign year    = f_val[I_YR];
  assign century = f_val[I_CEN];
  assign weekday = f_val[I_WDAY];

  // R10: the midnight tick clears the time and moves the date in one cycle
  assert_midnight_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (step && !load && seconds == 8'h59 && minutes == 8'h59 && hours == HOUR_LAST)
    |=> (hours == 8'h00 && minutes == 8'h00 && seconds == 8'h00 &&
         !$stable(mday)));

  // R6: century end rolls every calendar field together
  assert_century_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (step && !load && seconds == 8'h59 && minutes == 8'h59 && hours == HOUR_LAST &&
     mday == 8'h31 && month == 8'h12 && year == 8'h99 && century == CENT_LAST)
    |=> (century == 8'h00 && year == 8'h00 && month == 8'h01 && mday == 8'h01));

  // R7: the weekday wraps at midnight regardless of the date
  assert_weekday_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (step && !load && seconds == 8'h59 && minutes == 8'h59 &&
     hours == HOUR_LAST && weekday == WEEK_LAST) |=> (weekday == 8'h01));

  // R8: halt blocks every update when no load is present
  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (halt && !load) |=> ($stable(seconds) && $stable(hours) && $stable(mday)));
endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  typedef struct packed {
    logic [63:0] start;
    logic [15:0] ticks;
    logic [63:0] expect_v;
  } vec_t;

  // Packing: {century, year, month, date, weekday, hours, minutes, seconds}
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{64'h19_99_12_31_07_23_59_59, 16'd1,    64'h20_00_01_01_01_00_00_00}, // R10 R6 R7
    '{64'h20_24_02_28_03_23_59_59, 16'd1,    64'h20_24_02_29_04_00_00_00}, // R5 leap 24
    '{64'h20_23_02_28_03_23_59_59, 16'd1,    64'h20_23_03_01_04_00_00_00}, // R4 common Feb
    '{64'h20_24_02_29_04_23_59_59, 16'd1,    64'h20_24_03_01_05_00_00_00}, // R4 leap Feb end
    '{64'h20_24_04_30_02_23_59_59, 16'd1,    64'h20_24_05_01_03_00_00_00}, // R4 30-day
    '{64'h20_24_01_30_02_23_59_59, 16'd1,    64'h20_24_01_31_03_00_00_00}, // R4 31-day
    '{64'h20_24_11_30_06_23_59_59, 16'd1,    64'h20_24_12_01_07_00_00_00}, // R4 month 11
    '{64'h39_99_12_31_05_23_59_59, 16'd1,    64'h00_00_01_01_06_00_00_00}, // R6 century wrap
    '{64'h20_12_02_28_01_23_59_59, 16'd1,    64'h20_12_02_29_02_00_00_00}, // R5 odd tens 2
    '{64'h20_10_02_28_01_23_59_59, 16'd1,    64'h20_10_03_01_02_00_00_00}, // R5 odd tens 0
    '{64'h20_00_02_28_01_23_59_59, 16'd1,    64'h20_00_02_29_02_00_00_00}, // R5 year 00
    '{64'h20_24_06_15_03_00_00_00, 16'd75,   64'h20_24_06_15_03_00_01_15}, // R2
    '{64'h20_24_06_15_03_09_59_59, 16'd1,    64'h20_24_06_15_03_10_00_00}, // R3 digit carry
    '{64'h20_24_06_15_03_00_00_75, 16'd1,    64'h20_24_06_15_03_00_00_76}, // R11 seconds
    '{64'h20_24_06_15_03_25_59_59, 16'd1,    64'h20_24_06_15_03_26_00_00}, // R11 hours
    '{64'h20_24_06_14_07_23_59_59, 16'd1,    64'h20_24_06_15_01_00_00_00}, // R7 weekday wrap
    '{64'h20_24_06_15_03_23_00_00, 16'd3600, 64'h20_24_06_16_04_00_00_00}  // R3 R9 one hour
  };
  localparam string VTAG [NV] = '{"R10", "R5", "R4", "R4", "R4", "R4", "R4", "R6",
                                  "R5", "R5", "R5", "R2", "R3", "R11", "R11", "R7", "R3"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, halt = 1'b0, load = 1'b0;
  logic [63:0] ld_all = '0;
  logic [7:0] seconds, minutes, hours, weekday, mday, month, year, century;
  logic [63:0] now;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign now = {century, year, month, mday, weekday, hours, minutes, seconds};

  bcd_calendar i_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .halt(halt), .load(load),
    .ld_seconds(ld_all[7:0]),   .ld_minutes(ld_all[15:8]),
    .ld_hours(ld_all[23:16]),   .ld_weekday(ld_all[31:24]),
    .ld_mday(ld_all[39:32]),    .ld_month(ld_all[47:40]),
    .ld_year(ld_all[55:48]),    .ld_century(ld_all[63:56]),
    .seconds(seconds), .minutes(minutes), .hours(hours), .weekday(weekday),
    .mday(mday), .month(month), .year(year), .century(century)
  );

  task automatic check(input string req, input logic [63:0] exp_v);
    n_checks++;
    if (now !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, now, exp_v);
    end
  endtask

  task automatic do_load(input logic [63:0] v);
    @(negedge clk);
    ld_all = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(negedge clk);
    end
    sec_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 64'h00_00_01_01_01_00_00_00);

    for (int v = 0; v < NV; v++) begin
      do_load(VECS[v].start);
      check("R9", VECS[v].start);
      run_ticks(int'(VECS[v].ticks));
      check(VTAG[v], VECS[v].expect_v);
    end

    // R8: halt freezes all fields despite ticks
    do_load(64'h20_24_06_15_03_23_59_59);
    halt = 1'b1;
    run_ticks(5);
    check("R8", 64'h20_24_06_15_03_23_59_59);
    halt = 1'b0;
    run_ticks(1);
    check("R8", 64'h20_24_06_16_04_00_00_00);

    // R9: load wins over a tick in the same cycle
    @(negedge clk);
    ld_all = 64'h21_05_07_04_02_12_30_45;
    load = 1'b1;
    sec_tick = 1'b1;
    @(negedge clk);
    load = 1'b0;
    sec_tick = 1'b0;
    check("R9", 64'h21_05_07_04_02_12_30_45);
    run_ticks(1);
    check("R9", 64'h21_05_07_04_02_12_30_46);

    // R1: reset in mid-run returns the reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 64'h00_00_01_01_01_00_00_00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_ticks(1);
    check("R2", 64'h00_00_01_01_01_00_00_01);

    done = 1'b1;
    finish_run();
  end
endmodule